// File: doc/BRIEF.md
# Snooping Bus Transaction Master

This block is the bus-side half of a per-processor cache controller on a shared, atomic snooping bus. The processor-side controller hands it one request at a time: a read miss, a read-for-ownership, an upgrade of a Shared block to Modified, or the write-back of a dirty victim. The block then runs that request as a single bus transaction. It raises a request to the arbiter and waits for the grant. It then drives the command and block address, holds them until the addressed device accepts, and finally moves the data if the command has a data phase. When the transaction completes it reports back to the processor side with a one-cycle completion pulse.

The pending request remains live while the grant is awaited. Snoops from other masters are answered on every cycle, with a registered response one cycle after each snoop. An upgrade whose block is invalidated by another master before the grant arrives is rewritten into a read-exclusive, and the completion reports that changed command. A dirty block that is waiting to be written back is supplied to a snooping reader. If that reader wants ownership, the write-back is abandoned. After the grant, any snoop to the block in flight is told to retry until the local transaction finishes. This keeps ownership from being taken away before the processor's write lands. A completion of an upgrade or read-exclusive is the point at which the processor side may write the block.

Top module: `snoop_bus_master`

## Requirements
- R1: A request is taken only while `req_ready` is high. On the following cycle `bus_req` is high, and it stays high, with no address phase, until `bus_gnt` is sampled high.
- R2: On the clock edge that samples `bus_gnt` high, `bus_req` falls and `a_valid` rises, carrying `a_cmd` and the pending block address on `a_addr`. Both stay stable until `a_ack` is sampled high, and `bus_req` is never high while `a_valid` is high.
- R3: Commands are 2-bit codes: 00 read, 01 read-exclusive, 10 upgrade, 11 write-back. For a read or read-exclusive, after acceptance the block waits for `d_in_valid`. It then pulses `done` for one cycle with `done_data` equal to `d_in` and `done_cmd` equal to the issued command.
- R4: An upgrade has no data phase. `done` pulses on the cycle right after acceptance, with `done_cmd` 10 and `done_data` zero.
- R5: A write-back drives `d_out_valid` for exactly one cycle after acceptance, with `d_out` equal to the request's write data. `done` follows on the next cycle with `done_cmd` 11.
- R6: If, while an upgrade awaits the grant, a snoop with command read-exclusive (01) or upgrade (10) targets the same block, the address phase carries 01, a data phase follows, and `done_cmd` is 01. A read snoop (00) to that block leaves the upgrade unchanged.
- R7: Every snoop gets `resp_valid` on the next cycle. A snoop to a different block while the grant is awaited gets neither retry nor flush, and the pending request goes on undisturbed.
- R8: While a write-back awaits the grant, a read snoop (00) to the same block gets `resp_flush` with `resp_data` equal to the dirty data, and the write-back still runs to completion.
- R9: While a write-back awaits the grant, a read-exclusive or upgrade snoop to the same block gets `resp_flush` with the dirty data. On the next cycle `bus_req` is low, and `done` pulses with `done_drop` high, `done_cmd` 11, and no address phase.
- R10: From the cycle after the grant until `done`, a snoop to the pending block gets `resp_retry`. A snoop to another block does not.
- R11: `req_valid` is ignored while `req_ready` is low: no second transaction is started and the address in flight is not altered.
- R12: After reset, `req_ready` is high and `bus_req`, `a_valid`, `d_out_valid`, `done` and `resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor-side request strobe |
| req_ready | output | 1 | High when a new request can be taken |
| req_cmd | input | 2 | Requested command code |
| req_addr | input | AW | Block address of the request |
| req_wdata | input | DW | Dirty block data for a write-back |
| done | output | 1 | One-cycle completion pulse |
| done_cmd | output | 2 | Command that was finally carried out |
| done_drop | output | 1 | Write-back abandoned after a snoop took the data |
| done_data | output | DW | Block data returned by a read or read-exclusive |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| a_valid | output | 1 | Address phase valid |
| a_cmd | output | 2 | Command on the bus |
| a_addr | output | AW | Block address on the bus |
| a_ack | input | 1 | Address phase accepted by the target |
| d_out_valid | output | 1 | Outgoing write-back data valid |
| d_out | output | DW | Outgoing write-back data |
| d_in_valid | input | 1 | Incoming block data valid |
| d_in | input | DW | Incoming block data |
| snp_valid | input | 1 | Another master's transaction is visible for snooping |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | AW | Block address of the snooped transaction |
| resp_valid | output | 1 | Snoop response valid |
| resp_retry | output | 1 | Snooper must retry: block is in flight here |
| resp_flush | output | 1 | This master supplies dirty data |
| resp_data | output | DW | Supplied dirty data |

## Verification
Each of the four commands is run with different grant and acceptance delays. This separates a correct hold of request, command and address from an off-by-one in the handshake, and separates the data-less upgrade from the read and write-back data phases. Snoops are injected while the grant is awaited, using every combination that matters: an invalidating snoop on a pending upgrade (it must become a read-exclusive), a read snoop on the same upgrade (it must stay), a snoop to an unrelated block (nothing may change), and read versus ownership snoops on a pending write-back (flush and keep, against flush and abandon). A hit and a miss during the address phase tell the retry window apart from plain address matching. A second request presented while busy shows that the held request cannot be overwritten.

// File: rtl/snb_pkg.sv
package snb_pkg;

  typedef enum logic [1:0] {
    CMD_RD  = 2'b00,
    CMD_RDX = 2'b01,
    CMD_UPG = 2'b10,
    CMD_WB  = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA
  } seq_st_e;

  function automatic logic takes_ownership(cmd_e c);
    return (c == CMD_RDX) || (c == CMD_UPG);
  endfunction

endpackage

// File: rtl/snb_snoop_unit.sv
module snb_snoop_unit
  import snb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snp_valid,
  input  cmd_e          snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  logic          pend_wait,
  input  logic          pend_transit,
  input  cmd_e          pend_cmd,
  input  logic [AW-1:0] pend_addr,
  input  logic [DW-1:0] pend_wdata,
  output logic          upg_lost,
  output logic          wb_taken,
  output logic          resp_valid,
  output logic          resp_retry,
  output logic          resp_flush,
  output logic [DW-1:0] resp_data
);

  logic same_blk;
  logic inval;
  logic wb_hit;
  logic busy_hit;

  always_comb begin
    same_blk = snp_valid && (snp_addr == pend_addr);
    inval    = takes_ownership(snp_cmd);
    upg_lost = same_blk && pend_wait && (pend_cmd == CMD_UPG) && inval;
    wb_hit   = same_blk && pend_wait && (pend_cmd == CMD_WB);
    wb_taken = wb_hit && inval;
    busy_hit = same_blk && pend_transit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_retry <= 1'b0;
      resp_flush <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= snp_valid;
      resp_retry <= busy_hit;
      resp_flush <= wb_hit;
      resp_data  <= wb_hit ? pend_wdata : '0;
    end
  end

endmodule

// File: rtl/snb_seq.sv
module snb_seq
  import snb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  cmd_e          req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          bus_gnt,
  input  logic          a_ack,
  input  logic          d_in_valid,
  input  logic [DW-1:0] d_in,
  input  logic          upg_lost,
  input  logic          wb_taken,
  output logic          bus_req,
  output logic          a_valid,
  output cmd_e          a_cmd,
  output logic [AW-1:0] a_addr,
  output logic          d_out_valid,
  output logic [DW-1:0] d_out,
  output logic          done,
  output cmd_e          done_cmd,
  output logic          done_drop,
  output logic [DW-1:0] done_data,
  output logic          pend_wait,
  output logic          pend_transit,
  output cmd_e          pend_cmd,
  output logic [AW-1:0] pend_addr,
  output logic [DW-1:0] pend_wdata
);

  seq_st_e st;
  cmd_e    issue_cmd;

  always_comb begin
    req_ready    = (st == ST_IDLE);
    pend_wait    = (st == ST_ARB);
    pend_transit = (st == ST_ADDR) || (st == ST_RDATA) || (st == ST_WDATA);
    issue_cmd    = upg_lost ? CMD_RDX : pend_cmd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bus_req     <= 1'b0;
      a_valid     <= 1'b0;
      a_cmd       <= CMD_RD;
      a_addr      <= '0;
      d_out_valid <= 1'b0;
      d_out       <= '0;
      done        <= 1'b0;
      done_cmd    <= CMD_RD;
      done_drop   <= 1'b0;
      done_data   <= '0;
      pend_cmd    <= CMD_RD;
      pend_addr   <= '0;
      pend_wdata  <= '0;
    end else begin
      done        <= 1'b0;
      d_out_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            pend_cmd   <= req_cmd;
            pend_addr  <= req_addr;
            pend_wdata <= req_wdata;
            bus_req    <= 1'b1;
            st         <= ST_ARB;
          end
        end
        ST_ARB: begin
          if (wb_taken) begin
            bus_req   <= 1'b0;
            done      <= 1'b1;
            done_cmd  <= CMD_WB;
            done_drop <= 1'b1;
            done_data <= '0;
            st        <= ST_IDLE;
          end else begin
            pend_cmd <= issue_cmd;
            if (bus_gnt) begin
              bus_req <= 1'b0;
              a_valid <= 1'b1;
              a_cmd   <= issue_cmd;
              a_addr  <= pend_addr;
              st      <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          if (a_ack) begin
            a_valid <= 1'b0;
            if (pend_cmd == CMD_UPG) begin
              done      <= 1'b1;
              done_cmd  <= CMD_UPG;
              done_drop <= 1'b0;
              done_data <= '0;
              st        <= ST_IDLE;
            end else if (pend_cmd == CMD_WB) begin
              d_out_valid <= 1'b1;
              d_out       <= pend_wdata;
              st          <= ST_WDATA;
            end else begin
              st <= ST_RDATA;
            end
          end
        end
        ST_WDATA: begin
          done      <= 1'b1;
          done_cmd  <= CMD_WB;
          done_drop <= 1'b0;
          done_data <= '0;
          st        <= ST_IDLE;
        end
        ST_RDATA: begin
          if (d_in_valid) begin
            done      <= 1'b1;
            done_cmd  <= pend_cmd;
            done_drop <= 1'b0;
            done_data <= d_in;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/snoop_bus_master.sv
module snoop_bus_master
  import snb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [1:0]    done_cmd,
  output logic          done_drop,
  output logic [DW-1:0] done_data,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          a_valid,
  output logic [1:0]    a_cmd,
  output logic [AW-1:0] a_addr,
  input  logic          a_ack,
  output logic          d_out_valid,
  output logic [DW-1:0] d_out,
  input  logic          d_in_valid,
  input  logic [DW-1:0] d_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          resp_valid,
  output logic          resp_retry,
  output logic          resp_flush,
  output logic [DW-1:0] resp_data
);

  logic          upg_lost;
  logic          wb_taken;
  logic          pend_wait;
  logic          pend_transit;
  cmd_e          pend_cmd;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_wdata;
  cmd_e          a_cmd_e;
  cmd_e          done_cmd_e;

  snb_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_cmd      (cmd_e'(req_cmd)),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_ready    (req_ready),
    .bus_gnt      (bus_gnt),
    .a_ack        (a_ack),
    .d_in_valid   (d_in_valid),
    .d_in         (d_in),
    .upg_lost     (upg_lost),
    .wb_taken     (wb_taken),
    .bus_req      (bus_req),
    .a_valid      (a_valid),
    .a_cmd        (a_cmd_e),
    .a_addr       (a_addr),
    .d_out_valid  (d_out_valid),
    .d_out        (d_out),
    .done         (done),
    .done_cmd     (done_cmd_e),
    .done_drop    (done_drop),
    .done_data    (done_data),
    .pend_wait    (pend_wait),
    .pend_transit (pend_transit),
    .pend_cmd     (pend_cmd),
    .pend_addr    (pend_addr),
    .pend_wdata   (pend_wdata)
  );

  snb_snoop_unit #(.AW(AW), .DW(DW)) u_snoop (
    .clk          (clk),
    .rst          (rst),
    .snp_valid    (snp_valid),
    .snp_cmd      (cmd_e'(snp_cmd)),
    .snp_addr     (snp_addr),
    .pend_wait    (pend_wait),
    .pend_transit (pend_transit),
    .pend_cmd     (pend_cmd),
    .pend_addr    (pend_addr),
    .pend_wdata   (pend_wdata),
    .upg_lost     (upg_lost),
    .wb_taken     (wb_taken),
    .resp_valid   (resp_valid),
    .resp_retry   (resp_retry),
    .resp_flush   (resp_flush),
    .resp_data    (resp_data)
  );

  assign a_cmd    = a_cmd_e;
  assign done_cmd = done_cmd_e;

endmodule

// File: rtl/snb_chk.sv
module snb_chk #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          done,
  input logic [1:0]    done_cmd,
  input logic          done_drop,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          a_valid,
  input logic [1:0]    a_cmd,
  input logic [AW-1:0] a_addr,
  input logic          a_ack,
  input logic          d_out_valid,
  input logic          snp_valid,
  input logic          resp_valid,
  input logic          resp_retry,
  input logic          resp_flush
);

  // R1
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt |=> bus_req || done_drop);

  // R2
  req_addr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && a_valid));

  // R2
  gnt_to_addr_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_gnt && !snp_valid |=> a_valid && !bus_req);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    a_valid && !a_ack |=> a_valid && $stable(a_cmd) && $stable(a_addr));

  // R5
  wb_data_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    d_out_valid |=> done && done_cmd == 2'b11 && !done_drop && !d_out_valid);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  retry_resp_chk: assert property (@(posedge clk) disable iff (rst)
    resp_retry |-> resp_valid && !resp_flush);

  // R7
  resp_follows_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> resp_valid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !bus_req && !a_valid);

endmodule

bind snoop_bus_master snb_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_snoop_bus_master.sv
`timescale 1ns/1ps
module tb_snoop_bus_master;

  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_cmd = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          done;
  logic [1:0]    done_cmd;
  logic          done_drop;
  logic [DW-1:0] done_data;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic          a_valid;
  logic [1:0]    a_cmd;
  logic [AW-1:0] a_addr;
  logic          a_ack = 1'b0;
  logic          d_out_valid;
  logic [DW-1:0] d_out;
  logic          d_in_valid = 1'b0;
  logic [DW-1:0] d_in = '0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic          resp_valid;
  logic          resp_retry;
  logic          resp_flush;
  logic [DW-1:0] resp_data;

  always #2.5 clk = ~clk;

  snoop_bus_master #(.AW(AW), .DW(DW)) dut (.*);

  typedef struct packed {
    logic [1:0]    c;
    logic          d;
    logic [DW-1:0] v;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every completion pulse is matched against the queue
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11 unexpected completion", {62'b0, done_cmd}, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(done_cmd == e.c, "R3 done_cmd", {62'b0, done_cmd}, {62'b0, e.c});
        chk(done_drop == e.d, "R9 done_drop", {63'b0, done_drop}, {63'b0, e.d});
        chk(done_data == e.v, "R3 done_data", done_data, e.v);
      end
    end
  end

  task automatic run_txn(
    input logic [1:0]    c,
    input logic [AW-1:0] ad,
    input logic [DW-1:0] wd,
    input logic [DW-1:0] rd,
    input int            gwait,
    input int            await_n,
    input bit            s_en,
    input logic [1:0]    s_cmd,
    input logic [AW-1:0] s_addr,
    input bit            exp_flush,
    input bit            exp_drop,
    input logic [1:0]    expc,
    input bit            t_en,
    input bit            ig_en
  );
    exp_t e;
    req_valid = 1'b1; req_cmd = c; req_addr = ad; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_req && !req_ready, "R1 request raised", {63'b0, bus_req}, 1);
    for (int i = 0; i < gwait; i++) begin
      if (s_en && i == 0) begin
        snp_valid = 1'b1; snp_cmd = s_cmd; snp_addr = s_addr;
        if (exp_drop) begin
          e.c = 2'b11; e.d = 1'b1; e.v = '0;
          q.push_back(e);
        end
      end
      if (ig_en && i == 1) begin
        req_valid = 1'b1; req_cmd = 2'b01; req_addr = ad ^ 32'h40; req_wdata = '1;
      end
      @(negedge clk);
      snp_valid = 1'b0; req_valid = 1'b0;
      if (s_en && i == 0) begin
        chk(resp_valid && !resp_retry, "R7 snoop response", {63'b0, resp_valid}, 1);
        chk(resp_flush == exp_flush, "R8 flush flag", {63'b0, resp_flush}, {63'b0, exp_flush});
        chk(resp_data == (exp_flush ? wd : '0), "R8 flush data", resp_data, exp_flush ? wd : '0);
        if (exp_drop) begin
          chk(!bus_req && !a_valid, "R9 request dropped", {63'b0, bus_req}, 0);
          @(negedge clk);
          chk(!a_valid && req_ready, "R9 no address phase", {63'b0, a_valid}, 0);
          return;
        end
      end
      chk(bus_req && !a_valid, "R1 waiting for grant", {63'b0, bus_req}, 1);
      if (ig_en && i == 1) chk(!req_ready, "R11 busy", {63'b0, req_ready}, 0);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    chk(a_valid && !bus_req, "R2 address phase", {63'b0, a_valid}, 1);
    chk(a_cmd == expc, "R6 issued command", {62'b0, a_cmd}, {62'b0, expc});
    chk(a_addr == ad, "R11 issued address", {32'b0, a_addr}, {32'b0, ad});
    for (int i = 0; i < await_n; i++) begin
      if (t_en && i == 0) begin snp_valid = 1'b1; snp_cmd = 2'b00; snp_addr = ad; end
      if (t_en && i == 1) begin snp_valid = 1'b1; snp_cmd = 2'b01; snp_addr = ad ^ 32'h1; end
      @(negedge clk);
      snp_valid = 1'b0;
      chk(a_valid && a_cmd == expc && a_addr == ad, "R2 address held", {63'b0, a_valid}, 1);
      if (t_en && i == 0) chk(resp_valid && resp_retry, "R10 retry on hit", {63'b0, resp_retry}, 1);
      if (t_en && i == 1) chk(resp_valid && !resp_retry, "R10 no retry on miss", {63'b0, resp_retry}, 0);
    end
    e.c = expc; e.d = 1'b0;
    e.v = (expc == 2'b00 || expc == 2'b01) ? rd : '0;
    q.push_back(e);
    a_ack = 1'b1;
    @(negedge clk);
    a_ack = 1'b0;
    chk(!a_valid && !bus_req, "R2 address released", {63'b0, a_valid}, 0);
    if (expc == 2'b10) begin
      chk(done, "R4 upgrade done after accept", {63'b0, done}, 1);
    end else if (expc == 2'b11) begin
      chk(d_out_valid && d_out == wd, "R5 write-back data", d_out, wd);
      @(negedge clk);
      chk(!d_out_valid && done, "R5 write-back done", {63'b0, done}, 1);
    end else begin
      chk(!done, "R3 waits for data", {63'b0, done}, 0);
      @(negedge clk);
      d_in_valid = 1'b1; d_in = rd;
      @(negedge clk);
      d_in_valid = 1'b0;
      chk(done, "R3 read done", {63'b0, done}, 1);
    end
    @(negedge clk);
    chk(req_ready, "R11 back to idle", {63'b0, req_ready}, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !bus_req && !a_valid && !d_out_valid && !done && !resp_valid,
        "R12 reset state", {63'b0, req_ready}, 1);

    // R3 plain read
    run_txn(2'b00, 32'h1000, '0, 64'hA5A5_0001_2222_3333, 2, 1, 0, 2'b00, '0, 0, 0, 2'b00, 0, 0);
    // R10 read-exclusive with snoops during the address phase
    run_txn(2'b01, 32'h2000, '0, 64'h0BAD_CAFE_1234_5678, 0, 3, 0, 2'b00, '0, 0, 0, 2'b01, 1, 0);
    // R4 upgrade
    run_txn(2'b10, 32'h3000, '0, '0, 1, 0, 0, 2'b00, '0, 0, 0, 2'b10, 0, 0);
    // R5 write-back
    run_txn(2'b11, 32'h4000, 64'hDEAD_BEEF_0000_1111, '0, 1, 2, 0, 2'b00, '0, 0, 0, 2'b11, 0, 0);
    // R6 upgrade hit by read-exclusive snoop
    run_txn(2'b10, 32'h5000, '0, 64'h1111_2222_3333_4444, 2, 1, 1, 2'b01, 32'h5000, 0, 0, 2'b01, 0, 0);
    // R6 upgrade hit by upgrade snoop
    run_txn(2'b10, 32'h5040, '0, 64'h5555_6666_7777_8888, 2, 0, 1, 2'b10, 32'h5040, 0, 0, 2'b01, 0, 0);
    // R6 upgrade seen by a read snoop stays an upgrade
    run_txn(2'b10, 32'h5080, '0, '0, 2, 1, 1, 2'b00, 32'h5080, 0, 0, 2'b10, 0, 0);
    // R7 snoop to another block, R11 request while busy
    run_txn(2'b00, 32'h6000, '0, 64'h9999_AAAA_BBBB_CCCC, 3, 1, 1, 2'b01, 32'h7000, 0, 0, 2'b00, 0, 1);
    // R8 write-back supplies a reader and still runs
    run_txn(2'b11, 32'h8000, 64'h0123_4567_89AB_CDEF, '0, 2, 1, 1, 2'b00, 32'h8000, 1, 0, 2'b11, 0, 0);
    // R9 write-back taken by an ownership snoop
    run_txn(2'b11, 32'h9000, 64'hFEDC_BA98_7654_3210, '0, 2, 0, 1, 2'b01, 32'h9000, 1, 1, 2'b11, 0, 0);

    @(negedge clk);
    chk(q.size() == 0, "R3 all completions seen", 64'(q.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule